// File: doc/BRIEF.md
# Banked Pipelined Wide-Write Narrow-Read Memory

This block is a deep simple-dual-port memory. The write port stores a full row of several lanes in one cycle. The read port returns a single lane.

The storage is cut into independent bank groups, and each group holds one contiguous quarter of the word address space. Each group registers its own private copy of the write address, write data, write enable, read address and lane select. A group's write enable and read enable are set only when the address falls in that group's range. No single register therefore has to fan out to every storage cell.

Read data is registered inside each group, outside the array. A final stage then picks the answering group and registers the result together with a valid flag.

Against a plain registered read, the read path has one extra register on the input side and one on the output side. The block is meant to sit behind address and control logic that runs at a fast clock (about 250 MHz) with wide, deep storage behind it. The default depth is kept small for elaboration. The deep configuration of 2^14 words is chosen through the word-address parameter.

Top module: `banked_wide_mem`

## Requirements
- R1: One write with `wr_en` high stores the whole `wr_data` row at word `wr_addr`. Lane i of that row is bits [64*i+63 : 64*i].
- R2: The two least significant bits of `rd_addr` choose the lane that is returned, and the remaining upper bits are the word address.
- R3: The top two bits of the word address choose the bank group. A write or read touches only that group, so equal low addresses in different groups hold independent data.
- R4: A read sampled on rising edge k presents its lane on `rd_data` right after rising edge k+4. That is five register stages: source, group input, array, group output and final.
- R5: `rd_valid` is high for exactly one cycle for each read accepted with `rd_en` high, aligned with its data, and is low in every other cycle.
- R6: A read sampled on the same edge as a write to the same word returns the old contents. A read sampled one edge later returns the new contents.
- R7: Synchronous active-low reset clears the valid pipeline, so `rd_valid` is low during and right after reset. Stored words are kept through reset.
- R8: Reads may be issued on every cycle, interleaved with writes, and each is answered in issue order at the fixed latency.
- R9: With `wr_en` low, the values on `wr_addr` and `wr_data` change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| wr_en | input | 1 | Write request |
| wr_addr | input | WORD_AW (10) | Word address of the write |
| wr_data | input | LANE_W*LANES (256) | Full row to store |
| rd_en | input | 1 | Read request |
| rd_addr | input | WORD_AW+2 (12) | Word address in upper bits, lane in the low two bits |
| rd_valid | output | 1 | Read result present on rd_data |
| rd_data | output | LANE_W (64) | Selected lane of the addressed word |

## Verification
The whole array is first filled with random rows. After that, a long run of random interleaved writes and reads at full rate checks every returned lane against a reference model shifted by the fixed latency. This run exposes wrong latency, wrong lane order and misaligned group select.

Directed cases tell apart the properties that random traffic rarely isolates:
- the same low address in two different groups must return independent data;
- a same-edge read must return the old row, while the following read returns the new one;
- toggling the write address and data with the enable low must change nothing;
- a reset in the middle of in-flight reads must drop them but keep the stored rows.

// File: rtl/banked_wide_mem_pkg.sv
// Package: shared defaults for the banked wide-write memory.
// Assumes lane count and group count are powers of two.
package banked_wide_mem_pkg;
    localparam int DEF_LANE_W   = 64;
    localparam int DEF_LANES    = 4;
    localparam int DEF_GROUPS   = 4;
    localparam int DEF_WORD_AW  = 10;
    // Stages between the source registers and the final register:
    // group input, array read, group output.
    localparam int GROUP_STAGES = 3;
endpackage

// File: rtl/bw_delay_line.sv
// Module: bw_delay_line
// Delays a small control field by a fixed number of register stages so
// it stays aligned with a data path of the same depth. Carries no reset
// because its output is only consumed under a separately reset valid flag.
module bw_delay_line #(
    parameter int W      = 2,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] pipe_q [STAGES];
            // Shift the field one stage per clock.
            always_ff @(posedge clk) begin
                pipe_q[0] <= din;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_q[i] <= pipe_q[i-1];
                end
            end
            assign dout = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bw_bank_group.sv
// Module: bw_bank_group
// One bank group: a private input register set, a storage slice holding
// 2**(WORD_AW-GRP_W) rows, a registered row read and a registered lane
// output. It answers only addresses whose top GRP_W bits equal GROUP_ID.
// Assumes GRP_W >= 1. Stored rows are never reset.
module bw_bank_group #(
    parameter int LANE_W   = 64,
    parameter int LANES    = 4,
    parameter int WORD_AW  = 10,
    parameter int GRP_W    = 2,
    parameter int GROUP_ID = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        src_wr_en,
    input  logic [WORD_AW-1:0]          src_wr_addr,
    input  logic [LANE_W*LANES-1:0]     src_wr_data,
    input  logic                        src_rd_en,
    input  logic [WORD_AW-1:0]          src_rd_addr,
    input  logic [$clog2(LANES)-1:0]    src_lane,
    output logic                        wr_act,
    output logic                        out_valid,
    output logic [LANE_W-1:0]           out_data
);
    localparam int LSW      = $clog2(LANES);
    localparam int LOCAL_AW = WORD_AW - GRP_W;
    localparam int DEPTH    = 1 << LOCAL_AW;
    localparam int ROW_W    = LANE_W * LANES;
    localparam logic [GRP_W-1:0] MY_ID = GROUP_ID[GRP_W-1:0];

    logic                in_wr_en, in_rd_en;
    logic [LOCAL_AW-1:0] in_wr_addr, in_rd_addr;
    logic [ROW_W-1:0]    in_wr_data;
    logic [LSW-1:0]      in_lane;

    logic [ROW_W-1:0]    mem [DEPTH];
    logic [ROW_W-1:0]    arr_row;
    logic [LSW-1:0]      arr_lane;
    logic                arr_vld;

    // Group input stage: enables, decoded against this group's range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_wr_en <= 1'b0;
            in_rd_en <= 1'b0;
        end else begin
            in_wr_en <= src_wr_en && (src_wr_addr[WORD_AW-1 -: GRP_W] == MY_ID);
            in_rd_en <= src_rd_en && (src_rd_addr[WORD_AW-1 -: GRP_W] == MY_ID);
        end
    end

    // Group input stage: private copies of addresses, data and lane.
    always_ff @(posedge clk) begin
        in_wr_addr <= src_wr_addr[LOCAL_AW-1:0];
        in_rd_addr <= src_rd_addr[LOCAL_AW-1:0];
        in_wr_data <= src_wr_data;
        in_lane    <= src_lane;
    end

    // Storage slice: row write and registered row read (old data on collision).
    always_ff @(posedge clk) begin
        if (in_wr_en) begin
            mem[in_wr_addr] <= in_wr_data;
        end
        if (in_rd_en) begin
            arr_row <= mem[in_rd_addr];
        end
        arr_lane <= in_lane;
    end

    // Array-stage valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) arr_vld <= 1'b0;
        else        arr_vld <= in_rd_en;
    end

    // Group output stage: valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= arr_vld;
    end

    // Group output stage: lane extraction, outside the array.
    always_ff @(posedge clk) begin
        if (arr_vld) begin
            out_data <= arr_row[arr_lane*LANE_W +: LANE_W];
        end
    end

    assign wr_act = in_wr_en;

    // A write enable in the input stage must carry an address that maps here.
    AST_GRP_WRITE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        in_wr_en |-> ($past(src_wr_addr[WORD_AW-1 -: GRP_W]) == MY_ID)); // R3
endmodule

// File: rtl/banked_wide_mem.sv
// Module: banked_wide_mem (top)
// Wide-write, narrow-read memory split into GROUPS bank groups. One shared
// source register set feeds every group; each group re-registers its
// inputs and its read result; a delayed group select picks the answering
// group into a final output register. Read latency is five clock edges.
// Assumes LANES and GROUPS are powers of two and GROUPS >= 2.
module banked_wide_mem
    import banked_wide_mem_pkg::*;
#(
    parameter int LANE_W  = DEF_LANE_W,
    parameter int LANES   = DEF_LANES,
    parameter int GROUPS  = DEF_GROUPS,
    parameter int WORD_AW = DEF_WORD_AW
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [WORD_AW-1:0]                     wr_addr,
    input  logic [LANE_W*LANES-1:0]                wr_data,
    input  logic                                   rd_en,
    input  logic [WORD_AW+$clog2(LANES)-1:0]       rd_addr,
    output logic                                   rd_valid,
    output logic [LANE_W-1:0]                      rd_data
);
    localparam int LSW   = $clog2(LANES);
    localparam int GRP_W = $clog2(GROUPS);
    localparam int ROW_W = LANE_W * LANES;
    localparam int RD_AW = WORD_AW + LSW;

    logic               src_wr_en, src_rd_en;
    logic [WORD_AW-1:0] src_wr_addr, src_rd_word;
    logic [ROW_W-1:0]   src_wr_data;
    logic [LSW-1:0]     src_lane;

    logic [GROUPS-1:0]  grp_wr_act;
    logic [GROUPS-1:0]  grp_vld;
    logic [LANE_W-1:0]  grp_data [GROUPS];
    logic [GRP_W-1:0]   sel_d;

    // Shared source stage: enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_wr_en <= 1'b0;
            src_rd_en <= 1'b0;
        end else begin
            src_wr_en <= wr_en;
            src_rd_en <= rd_en;
        end
    end

    // Shared source stage: addresses and data.
    always_ff @(posedge clk) begin
        src_wr_addr <= wr_addr;
        src_wr_data <= wr_data;
        src_rd_word <= rd_addr[RD_AW-1:LSW];
        src_lane    <= rd_addr[LSW-1:0];
    end

    // Bank groups, one per quarter of the word space.
    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            bw_bank_group #(
                .LANE_W   (LANE_W),
                .LANES    (LANES),
                .WORD_AW  (WORD_AW),
                .GRP_W    (GRP_W),
                .GROUP_ID (g)
            ) u_grp (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_wr_en   (src_wr_en),
                .src_wr_addr (src_wr_addr),
                .src_wr_data (src_wr_data),
                .src_rd_en   (src_rd_en),
                .src_rd_addr (src_rd_word),
                .src_lane    (src_lane),
                .wr_act      (grp_wr_act[g]),
                .out_valid   (grp_vld[g]),
                .out_data    (grp_data[g])
            );
        end
    endgenerate

    // Group select delayed to line up with the group output registers.
    bw_delay_line #(.W(GRP_W), .STAGES(GROUP_STAGES)) u_sel_dly (
        .clk  (clk),
        .din  (src_rd_word[WORD_AW-1 -: GRP_W]),
        .dout (sel_d)
    );

    // Final stage: valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= |grp_vld;
    end

    // Final stage: registered group multiplexer.
    always_ff @(posedge clk) begin
        if (|grp_vld) begin
            rd_data <= grp_data[sel_d];
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_wr_act)); // R3
    AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_vld)); // R3
    AST_SEL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_vld) |-> grp_vld[sel_d]); // R4
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_vld) |=> rd_valid); // R5
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|grp_vld) |=> !rd_valid); // R5
endmodule

// File: tb/sim_banked_wide_mem.sv
module sim_banked_wide_mem;
    localparam int WAW = 10;
    localparam int NW  = 1 << WAW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [9:0]   wr_addr = '0;
    logic [255:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [11:0]  rd_addr = '0;
    logic         rd_valid;
    logic [63:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [255:0] ref_mem [NW];
    logic         pv [5];
    logic [63:0]  pd [5];
    string        pt [5];

    always #2.5 clk = ~clk;

    banked_wide_mem u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [255:0] rnd_row();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [63:0] lane_of(input logic [255:0] row, input logic [1:0] ln);
        return row[ln*64 +: 64];
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic clear_pipe();
        for (int i = 0; i < 5; i++) begin pv[i] = 1'b0; pd[i] = '0; pt[i] = "R4"; end
    endtask

    // One cycle: drive at negedge, model, advance, check oldest request.
    task automatic step(input logic we, input logic [9:0] wa, input logic [255:0] wd,
                        input logic re, input logic [11:0] ra, input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        for (int i = 4; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; pt[i] = pt[i-1]; end
        pv[0] = re;
        pd[0] = re ? lane_of(ref_mem[ra[11:2]], ra[1:0]) : '0;
        pt[0] = tag;
        if (we) ref_mem[wa] = wd;
        @(posedge clk);
        @(negedge clk);
        check("R5 valid", {63'd0, rd_valid}, {63'd0, pv[4]});
        if (pv[4] && rd_valid) check(pt[4], rd_data, pd[4]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, '0, "R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] a, b, c;
        void'($urandom(32'd4711));
        clear_pipe();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset valid", {63'd0, rd_valid}, 64'd0);
        rst_n = 1'b1;

        // R1: fill every word.
        for (int w = 0; w < NW; w++) step(1'b1, w[9:0], rnd_row(), 1'b0, '0, "R1");
        idle(3);

        // R1 / R2: read back all four lanes of a few words.
        for (int w = 0; w < 8; w++)
            for (int l = 0; l < 4; l++) step(1'b0, '0, '0, 1'b1, {w[9:0] * 10'd37, l[1:0]}, "R2");
        idle(5);

        // R3: same low address in group 0 and group 3.
        a = rnd_row(); b = rnd_row();
        step(1'b1, 10'h005, a, 1'b0, '0, "R3");
        step(1'b1, 10'h305, b, 1'b0, '0, "R3");
        idle(2);
        step(1'b0, '0, '0, 1'b1, {10'h005, 2'd3}, "R3");
        step(1'b0, '0, '0, 1'b1, {10'h305, 2'd3}, "R3");
        step(1'b0, '0, '0, 1'b1, {10'h305, 2'd0}, "R3");
        idle(5);

        // R6: same-edge read sees old row, next read sees new row.
        c = rnd_row();
        step(1'b1, 10'h1A2, c, 1'b1, {10'h1A2, 2'd1}, "R6");
        step(1'b0, '0, '0, 1'b1, {10'h1A2, 2'd1}, "R6");
        step(1'b0, '0, '0, 1'b1, {10'h1A2, 2'd2}, "R6");
        idle(5);

        // R9: address and data toggle with enable low.
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b0;
            step(1'b0, 10'h2B0, rnd_row(), 1'b0, '0, "R9");
        end
        idle(2);
        step(1'b0, '0, '0, 1'b1, {10'h2B0, 2'd0}, "R9");
        step(1'b0, '0, '0, 1'b1, {10'h2B0, 2'd2}, "R9");
        idle(5);

        // R7: reset with reads in flight; contents kept.
        step(1'b0, '0, '0, 1'b1, {10'h0F0, 2'd1}, "R7");
        step(1'b0, '0, '0, 1'b1, {10'h0F1, 2'd1}, "R7");
        rst_n = 1'b0;
        rd_en = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            check("R7 valid in reset", {63'd0, rd_valid}, 64'd0);
        end
        clear_pipe();
        rst_n = 1'b1;
        step(1'b0, '0, '0, 1'b0, '0, "R7");
        step(1'b0, '0, '0, 1'b1, {10'h0F0, 2'd1}, "R7");
        step(1'b0, '0, '0, 1'b1, {10'h3FF, 2'd3}, "R7");
        idle(5);

        // R4 / R8: random full-rate interleaved traffic.
        for (int i = 0; i < 4000; i++) begin
            logic we, re;
            we = ($urandom % 2) == 0;
            re = ($urandom % 10) < 8;
            step(we, 10'($urandom), rnd_row(), re, 12'($urandom), "R8");
        end
        idle(6);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule